// File: doc/BRIEF.md
# Single-Target Test Sequencer for a Testable Data Path

This block drives the control lines of a data path built for hierarchical testing, and tests one combinational module at a time. Each module has a fixed control sequence, its test plan, stored as a constant table. The plans do not all have the same length. A short index register picks the module under test. A one-bit pattern register holds the control-input bits of the current test pattern that the data path's inputs cannot supply while the plan runs.

Each pattern starts with a load cycle. In that cycle the index and pattern bits are taken from the primary inputs. The selected plan then replays for as many cycles as it has steps. A plan entry drives its control line in one of four ways: as a constant 0 or 1, as a don't-care (driven as 0), or as a pattern bit. A pattern bit comes either from a primary input that is free at that step or from the pattern register. A mode input switches the data path back to normal operation, which removes the enables of its test elements.

Top module: `tpc_top`

## Requirements
- R1: After a synchronous reset the sequencer is idle, the index and pattern registers are 0, `ctrl` is 0, `pattern_done` is 0 and, with `normal_mode` low, every `dft_en` bit is 1.
- R2: A `load` seen while idle in test mode captures the index from `pi[1:0]` and the pattern bit from `pi[2]`. A `load` while a plan is running, or while `normal_mode` is high, changes neither register.
- R3: After the load cycle the selected plan drives `ctrl` for exactly its length (3, 2, 3 and 2 steps for modules 0 to 3), so one pattern takes length+1 cycles. The sequencer then returns to idle with `ctrl` at 0.
- R4: Entries that are constant drive their value. Don't-care entries drive 0.
- R5: Entries fed by the pattern register drive the bit captured at load time, for the whole plan.
- R6: Entries fed by a free primary input follow that `pi` bit in the same cycle, with no register in between.
- R7: `pattern_done` is high for exactly one cycle, the cycle after a plan's last step. A `load` in that cycle starts the next pattern at once.
- R8: An index equal to or above the module count (`N_MODS`) starts no plan. `ctrl` stays 0 and no `pattern_done` follows.
- R9: While `normal_mode` is high, every `dft_en` bit and all of `ctrl` are 0 in the same cycle, and the sequencer is idle from the next cycle on. A plan that is cut off this way gives no `pattern_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| normal_mode | input | 1 | High selects normal operation and disables the test elements |
| load | input | 1 | Load cycle request; captures index and pattern bit from `pi` when idle |
| pi | input | PI_W (4) | Primary inputs: load fields at load time, free pattern bits during a plan |
| ctrl | output | N_CTRL (4) | Control lines to the data path |
| dft_en | output | N_DFT (2) | Enables for the data path's test elements |
| pattern_done | output | 1 | One-cycle pulse after the last step of a plan |

## Verification
The bench keeps a behavioural model of each plan, written as character strings, and compares both a default instance and one built with three modules on every cycle.

It targets these corner cases:
- A load in the `pattern_done` cycle. A design that needs an extra idle cycle there would lose the pattern.
- A load in the middle of a plan. A design that lets it through would corrupt the pattern-register bits that later steps use.
- Toggling the free `pi` bits during a step. This catches a pipelined or wrongly indexed pin path.
- An index beyond the module count. Here a wrong design would replay a table row.
- Switching to normal mode in the middle of a plan. A design that got this wrong would keep driving `ctrl` or still pulse `pattern_done`.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;

    localparam int PLAN_CNT = 4;
    localparam int ROW_CTRL = 4;

    typedef enum logic [2:0] {
        EK_ZERO = 3'd0,
        EK_ONE  = 3'd1,
        EK_DC   = 3'd2,
        EK_PIN  = 3'd3,
        EK_TPR  = 3'd4
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e  kind;
        logic [1:0] sel;
    } plan_ent_t;

    typedef plan_ent_t [ROW_CTRL-1:0] plan_row_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    function automatic int plan_len(int p);
        case (p)
            0:       return 3;
            1:       return 2;
            2:       return 3;
            3:       return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int max_plan_len();
        int m;
        m = 1;
        for (int p = 0; p < PLAN_CNT; p++)
            if (plan_len(p) > m) m = plan_len(p);
        return m;
    endfunction

    localparam int MAX_LEN = max_plan_len();

    function automatic plan_ent_t ent(ent_kind_e k, int s);
        plan_ent_t e;
        e.kind = k;
        e.sel  = 2'(s);
        return e;
    endfunction

    // Row layout: {ctrl3, ctrl2, ctrl1, ctrl0}
    function automatic plan_row_t plan_row(int p, int s);
        plan_row_t r;
        r = '0;
        if (p == 0 && s == 0) r = {ent(EK_ZERO,0), ent(EK_DC,0),   ent(EK_PIN,3),  ent(EK_ONE,0)};
        if (p == 0 && s == 1) r = {ent(EK_DC,0),   ent(EK_TPR,0),  ent(EK_ONE,0),  ent(EK_ZERO,0)};
        if (p == 0 && s == 2) r = {ent(EK_ONE,0),  ent(EK_ONE,0),  ent(EK_ZERO,0), ent(EK_DC,0)};
        if (p == 1 && s == 0) r = {ent(EK_PIN,0),  ent(EK_ONE,0),  ent(EK_ZERO,0), ent(EK_ZERO,0)};
        if (p == 1 && s == 1) r = {ent(EK_ONE,0),  ent(EK_ZERO,0), ent(EK_DC,0),   ent(EK_ONE,0)};
        if (p == 2 && s == 0) r = {ent(EK_DC,0),   ent(EK_ONE,0),  ent(EK_ONE,0),  ent(EK_TPR,0)};
        if (p == 2 && s == 1) r = {ent(EK_PIN,1),  ent(EK_DC,0),   ent(EK_ZERO,0), ent(EK_ONE,0)};
        if (p == 2 && s == 2) r = {ent(EK_ZERO,0), ent(EK_ZERO,0), ent(EK_ONE,0),  ent(EK_ZERO,0)};
        if (p == 3 && s == 0) r = {ent(EK_ONE,0),  ent(EK_ZERO,0), ent(EK_DC,0),   ent(EK_DC,0)};
        if (p == 3 && s == 1) r = {ent(EK_ZERO,0), ent(EK_ONE,0),  ent(EK_TPR,0),  ent(EK_ONE,0)};
        return r;
    endfunction

endpackage

// File: rtl/tpc_load_regs.sv
`timescale 1ns/1ps
module tpc_load_regs #(
    parameter int PI_W  = 4,
    parameter int TMR_W = 2,
    parameter int TPR_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [PI_W-1:0]  pi,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TPR_W-1:0] tpr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            tpr_q <= '0;
        end else if (capture) begin
            tmr_q <= pi[TMR_W-1:0];
            tpr_q <= pi[TMR_W +: TPR_W];
        end
    end

    // R2
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(tmr_q) && $stable(tpr_q)));

endmodule

// File: rtl/tpc_sequencer.sv
`timescale 1ns/1ps
module tpc_sequencer
    import tpc_pkg::*;
#(
    parameter int N_MODS = 4,
    parameter int TMR_W  = 2,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              normal_mode,
    input  logic              load,
    input  logic [TMR_W-1:0]  ld_tmr,
    input  logic [TMR_W-1:0]  tmr_q,
    output logic              capture,
    output logic              running,
    output logic [STEP_W-1:0] step_q,
    output logic              pattern_done
);

    seq_state_e state_q;
    logic       ld_valid;
    logic       last_step;

    assign ld_valid  = int'(ld_tmr) < N_MODS;
    assign last_step = int'(step_q) == plan_len(int'(tmr_q)) - 1;
    assign capture   = load && (state_q == SQ_IDLE) && !normal_mode;
    assign running   = state_q == SQ_RUN;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SQ_IDLE;
            step_q       <= '0;
            pattern_done <= 1'b0;
        end else begin
            pattern_done <= 1'b0;
            if (normal_mode) begin
                state_q <= SQ_IDLE;
                step_q  <= '0;
            end else begin
                case (state_q)
                    SQ_IDLE: begin
                        if (load && ld_valid) begin
                            state_q <= SQ_RUN;
                            step_q  <= '0;
                        end
                    end
                    SQ_RUN: begin
                        if (last_step) begin
                            state_q      <= SQ_IDLE;
                            step_q       <= '0;
                            pattern_done <= 1'b1;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                        end
                    end
                    default: state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        pattern_done |=> !pattern_done);

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (running && last_step && !normal_mode) |=> (pattern_done && !running));

    // R3
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (int'(step_q) < plan_len(int'(tmr_q))));

    // R8
    invalid_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && load && !ld_valid) |=> !running);

    // R9
    normal_idle_chk: assert property (@(posedge clk) disable iff (rst)
        normal_mode |=> !running);

endmodule

// File: rtl/tpc_plan_decode.sv
`timescale 1ns/1ps
module tpc_plan_decode
    import tpc_pkg::*;
#(
    parameter int N_MODS = 4,
    parameter int N_CTRL = 4,
    parameter int PI_W   = 4,
    parameter int TMR_W  = 2,
    parameter int TPR_W  = 1,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [TMR_W-1:0]  tmr,
    input  logic [STEP_W-1:0] step,
    input  logic [TPR_W-1:0]  tpr,
    input  logic [PI_W-1:0]   pi,
    output logic [N_CTRL-1:0] ctrl
);

    localparam int ROWS_P = 1 << TMR_W;
    localparam int ROWS_S = 1 << STEP_W;
    localparam int EFF    = (N_MODS < PLAN_CNT) ? N_MODS : PLAN_CNT;

    plan_row_t rom [ROWS_P][ROWS_S];
    plan_row_t row;
    logic [3:0] pi_x;
    logic [3:0] tpr_x;

    for (genvar p = 0; p < ROWS_P; p++) begin : g_plan
        for (genvar s = 0; s < ROWS_S; s++) begin : g_step
            if (p < EFF && s < plan_len(p)) begin : g_used
                assign rom[p][s] = plan_row(p, s);
            end else begin : g_blank
                assign rom[p][s] = '0;
            end
        end
    end

    always_comb begin
        pi_x            = '0;
        pi_x[PI_W-1:0]  = pi;
        tpr_x           = '0;
        tpr_x[TPR_W-1:0] = tpr;
        row = active ? rom[tmr][step] : '0;
    end

    for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
        if (c < ROW_CTRL) begin : g_drv
            always_comb begin
                case (row[c].kind)
                    EK_ONE:  ctrl[c] = 1'b1;
                    EK_PIN:  ctrl[c] = pi_x[row[c].sel];
                    EK_TPR:  ctrl[c] = tpr_x[row[c].sel];
                    default: ctrl[c] = 1'b0;
                endcase
            end
        end else begin : g_tie
            assign ctrl[c] = 1'b0;
        end
    end

    // R8
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(tmr) >= N_MODS) |-> (ctrl == '0));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> (ctrl == '0));

endmodule

// File: rtl/tpc_top.sv
`timescale 1ns/1ps
module tpc_top
    import tpc_pkg::*;
#(
    parameter int N_MODS = 4,
    parameter int N_CTRL = 4,
    parameter int PI_W   = 4,
    parameter int TPR_W  = 1,
    parameter int N_DFT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              normal_mode,
    input  logic              load,
    input  logic [PI_W-1:0]   pi,
    output logic [N_CTRL-1:0] ctrl,
    output logic [N_DFT-1:0]  dft_en,
    output logic              pattern_done
);

    localparam int TMR_W  = (N_MODS > 1) ? $clog2(N_MODS) : 1;
    localparam int STEP_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic              capture;
    logic              running;
    logic [STEP_W-1:0] step_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [TPR_W-1:0]  tpr_q;

    tpc_load_regs #(.PI_W(PI_W), .TMR_W(TMR_W), .TPR_W(TPR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .pi      (pi),
        .tmr_q   (tmr_q),
        .tpr_q   (tpr_q)
    );

    tpc_sequencer #(.N_MODS(N_MODS), .TMR_W(TMR_W), .STEP_W(STEP_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .normal_mode  (normal_mode),
        .load         (load),
        .ld_tmr       (pi[TMR_W-1:0]),
        .tmr_q        (tmr_q),
        .capture      (capture),
        .running      (running),
        .step_q       (step_q),
        .pattern_done (pattern_done)
    );

    tpc_plan_decode #(
        .N_MODS(N_MODS), .N_CTRL(N_CTRL), .PI_W(PI_W),
        .TMR_W(TMR_W), .TPR_W(TPR_W), .STEP_W(STEP_W)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .active (running && !normal_mode),
        .tmr    (tmr_q),
        .step   (step_q),
        .tpr    (tpr_q),
        .pi     (pi),
        .ctrl   (ctrl)
    );

    assign dft_en = {N_DFT{!normal_mode}};

    // R9
    normal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        normal_mode |-> ((ctrl == '0) && (dft_en == '0)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pattern_done |-> !running);

endmodule

// File: tb/tpc_top_bench.sv
`timescale 1ns/1ps
module tpc_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nm  = 1'b0;
    logic       ld  = 1'b0;
    logic [3:0] piv = 4'h0;
    logic [3:0] ctrl_a, ctrl_b;
    logic [1:0] dft_a, dft_b;
    logic       done_a, done_b;

    int checks = 0;
    int errors = 0;

    int m_run  [2];
    int m_step [2];
    int m_tmr  [2];
    int m_tpr  [2];
    int m_done [2];
    int nmods  [2];

    always #5 clk = ~clk;

    tpc_top u_tpc_top (
        .clk(clk), .rst(rst), .normal_mode(nm), .load(ld), .pi(piv),
        .ctrl(ctrl_a), .dft_en(dft_a), .pattern_done(done_a)
    );

    tpc_top #(.N_MODS(3)) u_tpc_top_n3 (
        .clk(clk), .rst(rst), .normal_mode(nm), .load(ld), .pi(piv),
        .ctrl(ctrl_b), .dft_en(dft_b), .pattern_done(done_b)
    );

    // char k drives control k: 0/1 constant, x don't care, t pattern register, a..d pi[0..3]
    function automatic string tbl(int p, int s);
        case ({p[3:0], s[3:0]})
            8'h00: return "1dx0";
            8'h01: return "01tx";
            8'h02: return "x011";
            8'h10: return "001a";
            8'h11: return "1x01";
            8'h20: return "t11x";
            8'h21: return "10xb";
            8'h22: return "0100";
            8'h30: return "xx01";
            8'h31: return "1t10";
            default: return "0000";
        endcase
    endfunction

    function automatic int tlen(int p);
        return (p == 0 || p == 2) ? 3 : 2;
    endfunction

    function automatic logic [3:0] exp_ctrl(int p, int s, logic [3:0] pv, int tp);
        string r;
        logic [3:0] v;
        r = tbl(p, s);
        v = '0;
        for (int k = 0; k < 4; k++) begin
            if (r[k] == "1") v[k] = 1'b1;
            else if (r[k] == "t") v[k] = tp[0];
            else if (r[k] >= "a" && r[k] <= "d") v[k] = pv[r[k] - 8'd97];
        end
        return v;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cyc(string tag, logic r, logic n, logic l, logic [3:0] p);
        logic [3:0] ec;
        int nd;
        @(negedge clk);
        rst = r; nm = n; ld = l; piv = p;
        #1;
        if (!r) begin
            for (int d = 0; d < 2; d++) begin
                ec = (!n && m_run[d] != 0) ? exp_ctrl(m_tmr[d], m_step[d], p, m_tpr[d]) : 4'h0;
                check(tag, d == 0 ? "ctrl" : "ctrl_n3", d == 0 ? int'(ctrl_a) : int'(ctrl_b), int'(ec));
                check(tag, d == 0 ? "done" : "done_n3", d == 0 ? int'(done_a) : int'(done_b), m_done[d]);
                check(tag, d == 0 ? "dft_en" : "dft_en_n3", d == 0 ? int'(dft_a) : int'(dft_b), n ? 0 : 3);
            end
        end
        @(posedge clk);
        for (int d = 0; d < 2; d++) begin
            if (r) begin
                m_run[d] = 0; m_step[d] = 0; m_tmr[d] = 0; m_tpr[d] = 0; m_done[d] = 0;
            end else begin
                nd = 0;
                if (n) begin
                    m_run[d] = 0; m_step[d] = 0;
                end else if (m_run[d] != 0) begin
                    if (m_step[d] == tlen(m_tmr[d]) - 1) begin
                        m_run[d] = 0; m_step[d] = 0; nd = 1;
                    end else begin
                        m_step[d]++;
                    end
                end else if (l) begin
                    m_tmr[d] = int'(p[1:0]);
                    m_tpr[d] = int'(p[2]);
                    if (m_tmr[d] < nmods[d]) begin
                        m_run[d] = 1; m_step[d] = 0;
                    end
                end
                m_done[d] = nd;
            end
        end
    endtask

    initial begin
        nmods[0] = 4; nmods[1] = 3;
        for (int d = 0; d < 2; d++) begin
            m_run[d] = 0; m_step[d] = 0; m_tmr[d] = 0; m_tpr[d] = 0; m_done[d] = 0;
        end
    end

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] lf;
        cyc("R1", 1, 0, 0, 4'h0);
        cyc("R1", 1, 0, 0, 4'h0);
        cyc("R1", 0, 0, 0, 4'h0);
        cyc("R1", 0, 0, 0, 4'hF);
        // R9: load in normal mode ignored
        cyc("R9", 0, 1, 1, 4'h1);
        cyc("R9", 0, 1, 0, 4'h0);
        cyc("R9", 0, 0, 0, 4'h0);
        // R4 R5 R6: plan 0, pattern bit 1, pi[3] toggled
        cyc("R3", 0, 0, 1, 4'b0100);
        cyc("R6", 0, 0, 0, 4'b1000);
        cyc("R5", 0, 0, 0, 4'b0000);
        cyc("R4", 0, 0, 0, 4'b1111);
        cyc("R7", 0, 0, 0, 4'h0);
        // plan 1, pi[0] toggles across the step
        cyc("R3", 0, 0, 1, 4'b0001);
        cyc("R6", 0, 0, 0, 4'b0001);
        cyc("R4", 0, 0, 0, 4'b0000);
        // R7: load in the done cycle, plan 2 with pattern bit 1
        cyc("R7", 0, 0, 1, 4'b0110);
        cyc("R5", 0, 0, 0, 4'b0000);
        cyc("R6", 0, 0, 0, 4'b0010);
        cyc("R4", 0, 0, 0, 4'b1111);
        // R8: index 3 on the three-module instance; plan 3 on the default one, pattern bit 0
        cyc("R8", 0, 0, 1, 4'b0011);
        cyc("R8", 0, 0, 0, 4'hF);
        cyc("R5", 0, 0, 0, 4'hF);
        cyc("R8", 0, 0, 0, 4'h0);
        // R2: load mid-plan must not alter the pattern bit (plan 0, bit 0)
        cyc("R2", 0, 0, 1, 4'b0000);
        cyc("R2", 0, 0, 1, 4'b0101);
        cyc("R2", 0, 0, 0, 4'h0);
        cyc("R2", 0, 0, 0, 4'h0);
        cyc("R2", 0, 0, 0, 4'h0);
        // R9: normal mode cuts a plan short, no done pulse
        cyc("R9", 0, 0, 1, 4'b0110);
        cyc("R9", 0, 1, 0, 4'hF);
        cyc("R9", 0, 0, 0, 4'hF);
        cyc("R9", 0, 0, 0, 4'h0);
        // R3: pseudo-random stress
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc("R3", lf[15:12] == 4'hF, lf[11:9] == 3'b111, lf[8], lf[3:0]);
        end
        cyc("R1", 1, 0, 0, 4'h0);
        cyc("R1", 0, 0, 0, 4'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule